// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical frame number. It does so by reading two 32-bit words from memory: a directory entry and then a table entry. Each address space is named by a 7-bit identifier. Every identifier has a directory base register, and software loads these registers in two steps. It first writes the identifier to a select register. It then writes a data word that holds the directory's physical address shifted right by 12, with the readable and writable attributes in the top bits.

A client presents a request carrying an identifier, an address and a read/write flag. The walker runs one walk at a time through a fixed sequence: idle, directory read, table read, respond. It returns either a frame number with the table entry's attribute bits, or a fault. A fault is reported without touching memory when the base register cannot serve the access. A fault is reported before the table read when the directory entry rejects the access.

Top module: `iova_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0.
- R2: A `cfg_base_we` write stores its data into the base register of the identifier most recently written through `cfg_sel_we`. Changing the select without a data write leaves every base register unchanged. Base data word: bits 21:0 hold the directory address shifted right by 12, bit 31 is readable and bit 30 is writable.
- R3: A request is answered with a fault and no memory read in these cases: its identifier's base register was never written since reset, or the base lacks the needed permission (bit 31 for a read, bit 30 for a write). The response comes in the cycle after acceptance.
- R4: The directory read address is {base frame, VA[31:22], 2'b00}.
- R5: The table read address is {directory entry bits 21:0, VA[21:12], 2'b00}.
- R6: A directory entry with bit 28 (next level) clear, or lacking the needed permission bit (31 for a read, 30 for a write), ends the walk with a fault and no table read.
- R7: An all-zero table entry gives a fault.
- R8: A table entry lacking the needed permission bit (31 for a read, 30 for a write) gives a fault.
- R9: On success, `rsp_pfn` equals table entry bits 21:0, and `rsp_readable`, `rsp_writable` and `rsp_nonsecure` equal table entry bits 31, 30 and 29.
- R10: Only one walk is outstanding. `req_ready` is 0 from acceptance through the response cycle and returns to 1 in the cycle after it. `rsp_valid` lasts one cycle.
- R11: A fault response drives `rsp_pfn`, `rsp_readable`, `rsp_writable` and `rsp_nonsecure` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_sel_we | input | 1 | Write strobe for the identifier select register |
| cfg_sel_asid | input | 7 | Identifier to select |
| cfg_base_we | input | 1 | Write strobe for the selected base register |
| cfg_base_data | input | 32 | Base word: attributes in bits 31:30, frame in bits 21:0 |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_asid | input | 7 | Request address-space identifier |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 34 | Physical byte address of the entry to read |
| mem_ack | input | 1 | Memory read data valid; may come in the same cycle as `mem_req` |
| mem_rdata | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_pfn | output | 22 | Physical frame number |
| rsp_readable | output | 1 | Table entry readable bit |
| rsp_writable | output | 1 | Table entry writable bit |
| rsp_nonsecure | output | 1 | Table entry non-secure bit |

## Verification
Random walks draw their identifiers from a mix of programmed and unprogrammed entries. The base registers carry random permissions, and the directory entries are random with next-level bits that are sometimes clear. Table indexes are drawn partly where entries are filled and partly where they are zero. This separates the early-fault paths (no read, one read) from full walks and from table-level faults, and each outcome is compared against a bench model. Both emitted addresses and the number of reads are checked as well. Directed cases cover reset state, reselecting without a data write, write access against read-only levels, and ready/response handshake timing.

// File: rtl/walker_pkg.sv
package walker_pkg;
   localparam int ENT_W     = 32;
   localparam int VA_W      = 32;
   localparam int IDX_W     = 10;
   localparam int PG_SHIFT  = 12;
   localparam int B_RD      = 31;
   localparam int B_WR      = 30;
   localparam int B_NS      = 29;
   localparam int B_NEXT    = 28;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIR  = 2'd1,
      ST_TBL  = 2'd2,
      ST_RESP = 2'd3
   } walk_state_e;

   function automatic logic perm_ok(input logic [ENT_W-1:0] e, input logic wr);
      return wr ? e[B_WR] : e[B_RD];
   endfunction
endpackage

// File: rtl/walker_base_table.sv
module walker_base_table #(
   parameter int ASID_W = 7,
   parameter int PFN_W  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic [ASID_W-1:0] sel_val,
   input  logic              data_we,
   input  logic [31:0]       data_val,
   input  logic [ASID_W-1:0] look_asid,
   output logic              look_valid,
   output logic              look_rd,
   output logic              look_wr,
   output logic [PFN_W-1:0]  look_pfn
);
   import walker_pkg::*;
   localparam int NUM = 1 << ASID_W;
   localparam int EW  = PFN_W + 2;

   logic [ASID_W-1:0] sel_q;
   logic [NUM-1:0]    vld;
   logic [EW-1:0]     ent [NUM];
   logic [EW-1:0]     wr_word;
   logic              unused_hi;

   assign wr_word   = {data_val[B_RD], data_val[B_WR], data_val[PFN_W-1:0]};
   assign unused_hi = ^data_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else if (sel_we) sel_q <= sel_val;
   end

   for (genvar i = 0; i < NUM; i++) begin : g_ent
      logic          v_q;
      logic [EW-1:0] e_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            e_q <= '0;
         end else if (data_we && sel_q == ASID_W'(i)) begin
            v_q <= 1'b1;
            e_q <= wr_word;
         end
      end
      assign vld[i] = v_q;
      assign ent[i] = e_q;
   end

   assign look_valid = vld[look_asid];
   assign look_rd    = ent[look_asid][EW-1];
   assign look_wr    = ent[look_asid][EW-2];
   assign look_pfn   = ent[look_asid][PFN_W-1:0];

   // R2: a data write lands in the entry chosen by the earlier select
   a_r2_data_lands: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |=> (vld[$past(sel_q)] && ent[$past(sel_q)] == $past(wr_word)));
endmodule

// File: rtl/walker_level_check.sv
module walker_level_check #(
   parameter bit IS_DIR = 1'b1
) (
   input  logic [31:0] entry,
   input  logic        wr,
   output logic        ok
);
   import walker_pkg::*;
   logic unused_e;
   assign unused_e = ^entry;

   if (IS_DIR) begin : g_dir
      assign ok = entry[B_NEXT] && perm_ok(entry, wr);
   end else begin : g_tbl
      assign ok = (entry != '0) && perm_ok(entry, wr);
   end
endmodule

// File: rtl/iova_walker.sv
module iova_walker #(
   parameter int PA_BITS = 34,
   parameter int ASID_W  = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_sel_we,
   input  logic [ASID_W-1:0]   cfg_sel_asid,
   input  logic                cfg_base_we,
   input  logic [31:0]         cfg_base_data,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ASID_W-1:0]   req_asid,
   input  logic [31:0]         req_va,
   input  logic                req_write,
   output logic                mem_req,
   output logic [PA_BITS-1:0]  mem_addr,
   input  logic                mem_ack,
   input  logic [31:0]         mem_rdata,
   output logic                rsp_valid,
   output logic                rsp_fault,
   output logic [PA_BITS-13:0] rsp_pfn,
   output logic                rsp_readable,
   output logic                rsp_writable,
   output logic                rsp_nonsecure
);
   import walker_pkg::*;
   localparam int PFN_W = PA_BITS - PG_SHIFT;

   if (PFN_W < 1 || PFN_W > B_NEXT) begin : g_bad_pa
      $error("iova_walker: PA_BITS gives a frame field that collides with attribute bits");
   end

   walk_state_e        st_q;
   logic [VA_W-1:0]    va_q;
   logic               wr_q;
   logic [PFN_W-1:0]   lvl_pfn_q;
   logic               fault_q, rd_q, wrb_q, ns_q;
   logic [PFN_W-1:0]   pfn_q;
   logic               b_valid, b_rd, b_wr;
   logic [PFN_W-1:0]   b_pfn;
   logic               dir_ok, tbl_ok, base_ok;
   logic [IDX_W-1:0]   idx;
   logic               unused_va;

   assign unused_va = ^{req_va[PG_SHIFT-1:0], va_q[PG_SHIFT-1:0]};

   walker_base_table #(.ASID_W(ASID_W), .PFN_W(PFN_W)) u_base (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_we    (cfg_sel_we),
      .sel_val   (cfg_sel_asid),
      .data_we   (cfg_base_we),
      .data_val  (cfg_base_data),
      .look_asid (req_asid),
      .look_valid(b_valid),
      .look_rd   (b_rd),
      .look_wr   (b_wr),
      .look_pfn  (b_pfn)
   );

   walker_level_check #(.IS_DIR(1'b1)) u_dir_chk (
      .entry(mem_rdata), .wr(wr_q), .ok(dir_ok));
   walker_level_check #(.IS_DIR(1'b0)) u_tbl_chk (
      .entry(mem_rdata), .wr(wr_q), .ok(tbl_ok));

   assign base_ok = b_valid && (req_write ? b_wr : b_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         lvl_pfn_q <= '0;
         fault_q   <= 1'b0;
         pfn_q     <= '0;
         rd_q      <= 1'b0;
         wrb_q     <= 1'b0;
         ns_q      <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q <= req_va;
                  wr_q <= req_write;
                  fault_q <= 1'b1;
                  pfn_q <= '0;
                  rd_q <= 1'b0;
                  wrb_q <= 1'b0;
                  ns_q <= 1'b0;
                  if (base_ok) begin
                     lvl_pfn_q <= b_pfn;
                     st_q      <= ST_DIR;
                  end else begin
                     st_q <= ST_RESP;
                  end
               end
            end
            ST_DIR: begin
               if (mem_ack) begin
                  if (dir_ok) begin
                     lvl_pfn_q <= mem_rdata[PFN_W-1:0];
                     st_q      <= ST_TBL;
                  end else begin
                     st_q <= ST_RESP;
                  end
               end
            end
            ST_TBL: begin
               if (mem_ack) begin
                  if (tbl_ok) begin
                     fault_q <= 1'b0;
                     pfn_q   <= mem_rdata[PFN_W-1:0];
                     rd_q    <= mem_rdata[B_RD];
                     wrb_q   <= mem_rdata[B_WR];
                     ns_q    <= mem_rdata[B_NS];
                  end
                  st_q <= ST_RESP;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idx           = (st_q == ST_DIR) ? va_q[VA_W-1:VA_W-IDX_W]
                                           : va_q[PG_SHIFT+IDX_W-1:PG_SHIFT];
   assign mem_req       = (st_q == ST_DIR) || (st_q == ST_TBL);
   assign mem_addr      = {lvl_pfn_q, idx, 2'b00};
   assign req_ready     = (st_q == ST_IDLE);
   assign rsp_valid     = (st_q == ST_RESP);
   assign rsp_fault     = fault_q;
   assign rsp_pfn       = pfn_q;
   assign rsp_readable  = rd_q;
   assign rsp_writable  = wrb_q;
   assign rsp_nonsecure = ns_q;

   // R3: a request the base cannot serve is answered next cycle, no read
   a_r3_base_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !base_ok) |=> (rsp_valid && rsp_fault && !mem_req));
   // R4: a pending read keeps its address until acknowledged
   a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   // R6: a directory entry without next-level bit ends the walk
   a_r6_dir_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DIR && mem_ack && !mem_rdata[B_NEXT]) |=> (rsp_valid && rsp_fault));
   // R10: response lasts one cycle and the walker is ready afterwards
   a_r10_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (req_ready && !rsp_valid));
   // R11: a fault carries no frame or attributes
   a_r11_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pfn == '0 && !rsp_readable && !rsp_writable && !rsp_nonsecure));
endmodule

// File: tb/sim_iova_walker.sv
module sim_iova_walker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_sel_we = 0;
   logic [6:0]  cfg_sel_asid = 0;
   logic        cfg_base_we = 0;
   logic [31:0] cfg_base_data = 0;
   logic        req_valid = 0;
   logic        req_ready;
   logic [6:0]  req_asid = 0;
   logic [31:0] req_va = 0;
   logic        req_write = 0;
   logic        mem_req;
   logic [33:0] mem_addr;
   logic        mem_ack = 0;
   logic [31:0] mem_rdata = 0;
   logic        rsp_valid, rsp_fault;
   logic [21:0] rsp_pfn;
   logic        rsp_readable, rsp_writable, rsp_nonsecure;

   always #(CLK_PERIOD/2) clk = ~clk;

   iova_walker u0 (.*);

   int n_chk = 0, n_fail = 0;
   logic [31:0] bmem [logic [33:0]];
   logic        bvld [128];
   logic        brd [128], bwr [128];
   logic [21:0] bpfn [128];
   logic [33:0] log_addr [4];
   int          log_n = 0;
   int          wait_cnt = 0;
   int          dir_sel [6];

   function automatic logic [31:0] rd(input logic [33:0] a);
      return bmem.exists(a) ? bmem[a] : 32'h0;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: answer each request after 0..2 idle cycles
   always @(negedge clk) begin
      if (mem_ack) mem_ack = 0;
      else if (rst_n && mem_req) begin
         if (wait_cnt == 0) begin
            mem_ack = 1;
            mem_rdata = rd(mem_addr);
            if (log_n < 4) log_addr[log_n] = mem_addr;
            log_n++;
            wait_cnt = $urandom % 3;
         end else wait_cnt--;
      end
   end

   task automatic sel_only(input logic [6:0] a);
      @(negedge clk); cfg_sel_we = 1; cfg_sel_asid = a;
      @(negedge clk); cfg_sel_we = 0;
   endtask
   task automatic data_only(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk); cfg_base_we = 1; cfg_base_data = d;
      @(negedge clk); cfg_base_we = 0;
      bvld[a] = 1; brd[a] = d[31]; bwr[a] = d[30]; bpfn[a] = d[21:0];
   endtask
   task automatic prog(input logic [6:0] a, input logic [31:0] d);
      sel_only(a);
      data_only(a, d);
   endtask

   task automatic ref_walk(input logic [6:0] a, input logic [31:0] va, input logic wr,
                           output logic f, output logic [21:0] pfn, output logic r, output logic w,
                           output logic ns, output int nrd, output logic [33:0] a0, output logic [33:0] a1);
      logic [31:0] pde, pte;
      f = 1; pfn = 0; r = 0; w = 0; ns = 0; nrd = 0; a0 = 0; a1 = 0;
      if (!bvld[a] || !(wr ? bwr[a] : brd[a])) return;
      a0 = {bpfn[a], va[31:22], 2'b00}; pde = rd(a0); nrd = 1;
      if (!pde[28] || !(wr ? pde[30] : pde[31])) return;
      a1 = {pde[21:0], va[21:12], 2'b00}; pte = rd(a1); nrd = 2;
      if (pte == 0 || !(wr ? pte[30] : pte[31])) return;
      f = 0; pfn = pte[21:0]; r = pte[31]; w = pte[30]; ns = pte[29];
   endtask

   task automatic do_walk(input logic [6:0] a, input logic [31:0] va, input logic wr, input string tag);
      logic ef, er, ew, ens; logic [21:0] ep; int en; logic [33:0] e0, e1; int cyc;
      ref_walk(a, va, wr, ef, ep, er, ew, ens, en, e0, e1);
      @(negedge clk);
      log_n = 0;
      req_valid = 1; req_asid = a; req_va = va; req_write = wr;
      @(negedge clk);
      req_valid = 0;
      cyc = 0;
      while (!rsp_valid && cyc < 100) begin
         // R10: no new request is taken while a walk is running
         chk(req_ready == 0, "R10 ready low during walk", req_ready, 0);
         @(negedge clk); cyc++;
      end
      if (cyc >= 100) begin
         chk(0, {tag, " watchdog"}, cyc, 0);
         return;
      end
      chk(rsp_fault == ef, {tag, " R6/R7/R8 fault"}, rsp_fault, ef);
      chk({rsp_pfn, rsp_readable, rsp_writable, rsp_nonsecure} == {ep, er, ew, ens},
          {tag, " R9/R11 payload"}, {rsp_pfn, rsp_readable, rsp_writable, rsp_nonsecure}, {ep, er, ew, ens});
      chk(log_n == en, {tag, " R3/R6 read count"}, log_n, en);
      if (en >= 1 && log_n >= 1) chk(log_addr[0] == e0, {tag, " R4 dir addr"}, log_addr[0], e0);
      if (en >= 2 && log_n >= 2) chk(log_addr[1] == e1, {tag, " R5 tbl addr"}, log_addr[1], e1);
      chk(req_ready == 0, "R10 ready in response cycle", req_ready, 0);
      @(negedge clk);
      chk(req_ready == 1 && rsp_valid == 0, "R10 ready after response", {req_ready, rsp_valid}, 2'b10);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 128; i++) begin bvld[i] = 0; brd[i] = 0; bwr[i] = 0; bpfn[i] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "R1 reset outputs",
          {req_ready, rsp_valid, mem_req}, 3'b100);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready == 1 && rsp_valid == 0 && mem_req == 0, "R1 after reset release",
          {req_ready, rsp_valid, mem_req}, 3'b100);

      // R3: never-programmed identifier
      do_walk(7'd100, 32'h1234_5678, 0, "R3 unprogrammed");

      // directed tables: identifier 20 RW base, 21 read-only base
      prog(7'd20, {2'b11, 8'h0, 22'h00_0100});
      sel_only(7'd21);                         // R2: reselect without data
      data_only(7'd21, {2'b10, 8'h0, 22'h00_0200});
      bmem[{22'h100, 10'd1, 2'b00}] = {4'b1101, 6'h0, 22'h00_0300};  // next, RW
      bmem[{22'h100, 10'd2, 2'b00}] = {4'b1100, 6'h0, 22'h00_0301};  // next clear
      bmem[{22'h100, 10'd3, 2'b00}] = {4'b1001, 6'h0, 22'h00_0302};  // read only
      bmem[{22'h200, 10'd1, 2'b00}] = {4'b1101, 6'h0, 22'h00_0310};
      bmem[{22'h300, 10'd5, 2'b00}] = {3'b111, 7'h0, 22'h2A_BCDE};
      bmem[{22'h300, 10'd6, 2'b00}] = {3'b101, 7'h0, 22'h00_0777};   // read-only page
      bmem[{22'h310, 10'd5, 2'b00}] = {3'b100, 7'h0, 22'h11_1111};
      bmem[{22'h302, 10'd0, 2'b00}] = {3'b111, 7'h0, 22'h00_0042};

      do_walk(7'd20, {10'd1, 10'd5, 12'h0AB}, 0, "R9 read hit");
      do_walk(7'd20, {10'd1, 10'd5, 12'h0AB}, 1, "R9 write hit");
      do_walk(7'd21, {10'd1, 10'd5, 12'h000}, 0, "R2 reselected base");
      do_walk(7'd21, {10'd1, 10'd5, 12'h000}, 1, "R3 write on read-only base");
      do_walk(7'd20, {10'd2, 10'd0, 12'h000}, 0, "R6 next clear");
      do_walk(7'd20, {10'd3, 10'd0, 12'h000}, 1, "R6 write on read-only dir");
      do_walk(7'd20, {10'd3, 10'd0, 12'h000}, 0, "R6 read through read-only dir");
      do_walk(7'd20, {10'd1, 10'd9, 12'h000}, 0, "R7 zero table entry");
      do_walk(7'd20, {10'd1, 10'd6, 12'h000}, 1, "R8 write on read-only page");
      do_walk(7'd20, {10'd1, 10'd6, 12'h000}, 0, "R8 read on read-only page");
      do_walk(7'd20, {10'd7, 10'd0, 12'h000}, 0, "R6 missing directory entry");

      // random tables for identifiers 1..8
      for (int k = 0; k < 6; k++) dir_sel[k] = (k * 173 + 5) % 1024;
      for (int a = 1; a <= 8; a++) begin
         logic [21:0] bp; logic [1:0] pm;
         bp = 22'($urandom) | 22'h1;
         pm = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
         prog(7'(a), {pm, 8'h0, bp});
         for (int k = 0; k < 6; k++) begin
            logic [21:0] tp; logic [31:0] pde;
            tp = 22'($urandom);
            pde = {($urandom % 5 != 0) ? 2'b11 : 2'($urandom), 1'b1,
                   ($urandom % 6 != 0), 6'h0, tp};
            bmem[{bp, 10'(dir_sel[k]), 2'b00}] = pde;
            for (int t = 0; t < 8; t++) begin
               if ($urandom % 4 != 0)
                  bmem[{tp, 10'(t), 2'b00}] = {($urandom % 4 != 0) ? 2'b11 : 2'($urandom),
                                               1'($urandom), 7'h0, 22'($urandom)};
            end
         end
      end
      for (int n = 0; n < 300; n++) begin
         logic [6:0] a; logic [31:0] va;
         a = 7'($urandom % 10);
         va = {10'(dir_sel[$urandom % 6]), 10'($urandom % 10), 12'($urandom)};
         do_walk(a, va, 1'($urandom), "R4/R5/R9 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule